// File: doc/BRIEF.md
# Pipeline Interlock and Stall Controller

This block decides, every cycle, whether the instruction sitting in decode of a scalar in-order five-stage pipeline may move on. It keeps its own small shadow of the destination fields of the instructions in execute, memory and writeback. It compares the two decode source fields with the destinations that are still in flight. When a read would see a stale value, it holds the fetch PC and the decode register in place, and the execute stage receives an empty slot in place of the decode instruction. The check is repeated each cycle until the hazard clears.

A parameter selects one of two policies. The no-bypass policy assumes no forwarding network, so any pending write in execute or memory blocks a reader. The load-use policy assumes that a forwarding network exists. It only blocks an instruction that depends on a load that has not yet left execute. A store's data operand is exempt, because that value can be forwarded later. The execute-stage control bits and the writeback write-enable and destination that the block exposes let the surrounding datapath use them directly.

Top module: `pipe_interlock`

## Requirements
- R1: With `MODE` = no-bypass, `stall_o` is high exactly when the decode instruction is valid and one of its valid source fields equals the valid, nonzero destination of a valid instruction in execute or in memory.
- R2: `pc_we_o` and `dec_we_o` are low in every cycle that `stall_o` is high and high in every other cycle.
- R3: The cycle after `stall_o` is high, execute holds an injected empty slot: `ex_bubble_o` = 1, `ex_valid_o` = 0, `ex_ctrl_o` = 0.
- R4: The stall is re-evaluated every cycle. In no-bypass mode a reader directly behind a writer stalls for exactly two cycles. A reader with one unrelated instruction between them stalls for exactly one cycle.
- R5: With `MODE` = load-use, source 1 causes a stall only when the instruction in execute is a valid load whose valid, nonzero destination equals it. Instructions in memory never cause a stall.
- R6: In load-use mode a source 2 match against such a load also stalls, except when the decode instruction is a store (`dec_is_store_i` = 1). In that case source 2 is ignored.
- R7: In load-use mode a load followed directly by a dependent instruction costs exactly one stall cycle. A load with an unrelated instruction after it costs none.
- R8: A comparison only counts when both the source and the destination valid bits are set. Register 0 never matches as a destination. While `dec_valid_i` is 0, `stall_o` is 0.
- R9: While `rst_ni` is low, execute, memory and writeback are empty: `stall_o`, `ex_valid_o`, `ex_bubble_o` and `wb_we_o` are 0.
- R10: A valid decode instruction that is not stalled appears in execute one cycle later with `ex_valid_o` = 1 and its control bits on `ex_ctrl_o`. Three cycles after it leaves decode, `wb_we_o` is 1 with `wb_dst_o` equal to its destination when that destination is valid and nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode stage holds an instruction |
| dec_src1_i | input | REG_W | First source register |
| dec_src1_vld_i | input | 1 | First source is read |
| dec_src2_i | input | REG_W | Second source register |
| dec_src2_vld_i | input | 1 | Second source is read |
| dec_dst_i | input | REG_W | Destination register |
| dec_dst_vld_i | input | 1 | Instruction writes its destination |
| dec_is_load_i | input | 1 | Decode instruction is a load |
| dec_is_store_i | input | 1 | Decode instruction is a store (source 2 is store data) |
| dec_ctrl_i | input | CTRL_W | Datapath control bits carried into execute |
| stall_o | output | 1 | Hazard: hold decode and PC, insert empty slot |
| pc_we_o | output | 1 | PC write enable |
| dec_we_o | output | 1 | Decode register write enable |
| ex_valid_o | output | 1 | Execute holds a real instruction |
| ex_bubble_o | output | 1 | Execute holds an injected empty slot |
| ex_ctrl_o | output | CTRL_W | Control bits of the execute instruction, zero when empty |
| wb_we_o | output | 1 | Register file write enable at writeback |
| wb_dst_o | output | REG_W | Register written at writeback |

## Verification
A corrupted shadow destination or a wrong load flag in execute shows up as a missing or spurious `stall_o` in the very cycle the decode fields are compared. A wrong pipeline advance shows up one cycle later on `ex_valid_o`, `ex_bubble_o` or `ex_ctrl_o`, and after three cycles on `wb_we_o` and `wb_dst_o`. The bench sweeps every writer and reader pairing of a four-register configuration, including register 0, the valid bits, the load and store flags and a gap of zero or one slot. It runs the sweep under both policies and compares every output in every cycle against an arithmetic model.

// File: rtl/pipe_interlock_pkg.sv
package pipe_interlock_pkg;
  typedef enum logic {
    ILK_NO_BYPASS = 1'b0,
    ILK_LOAD_USE  = 1'b1
  } ilk_mode_e;
endpackage

// File: rtl/ilk_match.sv
module ilk_match #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             src_vld_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             dst_vld_i,
  output logic             hit_o
);
  // register 0 is never a producer
  assign hit_o = src_vld_i & dst_vld_i & (|dst_i) & (src_i == dst_i);
endmodule

// File: rtl/ilk_stage.sv
module ilk_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/ilk_stall.sv
module ilk_stall
  import pipe_interlock_pkg::*;
#(
  parameter ilk_mode_e MODE = ILK_NO_BYPASS
) (
  input  logic       dec_valid_i,
  input  logic       dec_is_store_i,
  input  logic [1:0] hit_x_i,
  input  logic [1:0] hit_m_i,
  output logic       stall_o
);
  logic src2_en;

  // store data may be forwarded late when a bypass network exists
  assign src2_en = (MODE == ILK_LOAD_USE) ? ~dec_is_store_i : 1'b1;

  assign stall_o = dec_valid_i &
                   (hit_x_i[0] | hit_m_i[0] | ((hit_x_i[1] | hit_m_i[1]) & src2_en));
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_interlock_pkg::*;
#(
  parameter int        REG_W  = 5,
  parameter int        CTRL_W = 8,
  parameter ilk_mode_e MODE   = ILK_NO_BYPASS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_valid_i,
  input  logic [REG_W-1:0]  dec_src1_i,
  input  logic              dec_src1_vld_i,
  input  logic [REG_W-1:0]  dec_src2_i,
  input  logic              dec_src2_vld_i,
  input  logic [REG_W-1:0]  dec_dst_i,
  input  logic              dec_dst_vld_i,
  input  logic              dec_is_load_i,
  input  logic              dec_is_store_i,
  input  logic [CTRL_W-1:0] dec_ctrl_i,
  output logic              stall_o,
  output logic              pc_we_o,
  output logic              dec_we_o,
  output logic              ex_valid_o,
  output logic              ex_bubble_o,
  output logic [CTRL_W-1:0] ex_ctrl_o,
  output logic              wb_we_o,
  output logic [REG_W-1:0]  wb_dst_o
);
  localparam int NSRC = 2;
  localparam int NSTG = 2;              // compared stages: execute, memory
  localparam int XW   = 4 + REG_W + CTRL_W;
  localparam int MW   = 2 + REG_W;

  // execute stage: {vld, bub, ld, dv, dst, ctrl}
  logic [XW-1:0] x_d, x_q;
  logic          x_vld, x_bub, x_ld, x_dv;
  logic [REG_W-1:0]  x_dst;
  logic [CTRL_W-1:0] x_ctrl;
  // memory and writeback: {vld, dv, dst}
  logic [MW-1:0] m_q, w_q;
  logic          m_vld, m_dv, w_vld, w_dv;
  logic [REG_W-1:0] m_dst, w_dst;

  logic [REG_W-1:0] src     [NSRC];
  logic             src_vld [NSRC];
  logic [REG_W-1:0] stg_dst [NSTG];
  logic             stg_dv  [NSTG];
  logic [1:0]       hit_x, hit_m;
  logic             stall;

  assign {x_vld, x_bub, x_ld, x_dv, x_dst, x_ctrl} = x_q;
  assign {m_vld, m_dv, m_dst} = m_q;
  assign {w_vld, w_dv, w_dst} = w_q;

  assign src[0]     = dec_src1_i;
  assign src_vld[0] = dec_src1_vld_i;
  assign src[1]     = dec_src2_i;
  assign src_vld[1] = dec_src2_vld_i;

  assign stg_dst[0] = x_dst;
  assign stg_dst[1] = m_dst;

  generate
    if (MODE == ILK_LOAD_USE) begin : g_lu
      // only a load still in execute cannot be forwarded
      assign stg_dv[0] = x_vld & x_dv & x_ld;
      assign stg_dv[1] = 1'b0;
    end else begin : g_nb
      assign stg_dv[0] = x_vld & x_dv;
      assign stg_dv[1] = m_vld & m_dv;
    end
  endgenerate

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic hit;
      ilk_match #(.REG_W(REG_W)) u_match (
        .src_i     (src[k]),
        .src_vld_i (src_vld[k]),
        .dst_i     (stg_dst[s]),
        .dst_vld_i (stg_dv[s]),
        .hit_o     (hit)
      );
      if (s == 0) begin : g_x
        assign hit_x[k] = hit;
      end else begin : g_m
        assign hit_m[k] = hit;
      end
    end
  end

  ilk_stall #(.MODE(MODE)) u_stall (
    .dec_valid_i    (dec_valid_i),
    .dec_is_store_i (dec_is_store_i),
    .hit_x_i        (hit_x),
    .hit_m_i        (hit_m),
    .stall_o        (stall)
  );

  always_comb begin
    if (stall)
      x_d = {1'b0, 1'b1, {(XW-2){1'b0}}};
    else if (dec_valid_i)
      x_d = {1'b1, 1'b0, dec_is_load_i, dec_dst_vld_i, dec_dst_i, dec_ctrl_i};
    else
      x_d = '0;
  end

  ilk_stage #(.W(XW)) u_x (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(x_d), .q_o(x_q));
  ilk_stage #(.W(MW)) u_m (.clk_i(clk_i), .rst_ni(rst_ni), .d_i({x_vld, x_dv, x_dst}), .q_o(m_q));
  ilk_stage #(.W(MW)) u_w (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(m_q), .q_o(w_q));

  assign stall_o     = stall;
  assign pc_we_o     = ~stall;
  assign dec_we_o    = ~stall;
  assign ex_valid_o  = x_vld;
  assign ex_bubble_o = x_bub;
  assign ex_ctrl_o   = x_ctrl;
  assign wb_we_o     = w_vld & w_dv & (|w_dst);
  assign wb_dst_o    = w_dst;
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk
  import pipe_interlock_pkg::*;
#(
  parameter int        CTRL_W = 8,
  parameter ilk_mode_e MODE   = ILK_NO_BYPASS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dec_valid_i,
  input logic [CTRL_W-1:0] dec_ctrl_i,
  input logic              stall_o,
  input logic              ex_valid_o,
  input logic              ex_bubble_o,
  input logic [CTRL_W-1:0] ex_ctrl_o
);
  a_r3_bubble_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ex_bubble_o && !ex_valid_o && (ex_ctrl_o == '0));

  a_r10_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !stall_o) |=> ex_valid_o && !ex_bubble_o && (ex_ctrl_o == $past(dec_ctrl_i)));

  a_r8_idle_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !stall_o);

  generate
    if (MODE == ILK_LOAD_USE) begin : g_lu
      a_r7_single_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ex_bubble_o |-> !stall_o);
    end
  endgenerate
endmodule

bind pipe_interlock pipe_interlock_chk #(.CTRL_W(CTRL_W), .MODE(MODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dec_valid_i (dec_valid_i),
  .dec_ctrl_i  (dec_ctrl_i),
  .stall_o     (stall_o),
  .ex_valid_o  (ex_valid_o),
  .ex_bubble_o (ex_bubble_o),
  .ex_ctrl_o   (ex_ctrl_o)
);

// File: tb/pipe_interlock_bench.sv
`timescale 1ns/1ps
module pipe_interlock_bench;
  import pipe_interlock_pkg::*;
  localparam int REG_W  = 2;
  localparam int CTRL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic dv [2], s1v [2], s2v [2], dsv [2], ldi [2], sti [2];
  logic [REG_W-1:0]  s1 [2], s2 [2], ds [2];
  logic [CTRL_W-1:0] ct [2];
  logic stl [2], pwe [2], dwe [2], exv [2], exb [2], wbe [2];
  logic [CTRL_W-1:0] exc [2];
  logic [REG_W-1:0]  wbd [2];

  int n_chk = 0;
  int n_fail = 0;

  pipe_interlock #(.REG_W(REG_W), .CTRL_W(CTRL_W), .MODE(ILK_NO_BYPASS)) u_pipe_interlock (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv[0]),
    .dec_src1_i(s1[0]), .dec_src1_vld_i(s1v[0]), .dec_src2_i(s2[0]), .dec_src2_vld_i(s2v[0]),
    .dec_dst_i(ds[0]), .dec_dst_vld_i(dsv[0]), .dec_is_load_i(ldi[0]), .dec_is_store_i(sti[0]),
    .dec_ctrl_i(ct[0]), .stall_o(stl[0]), .pc_we_o(pwe[0]), .dec_we_o(dwe[0]),
    .ex_valid_o(exv[0]), .ex_bubble_o(exb[0]), .ex_ctrl_o(exc[0]),
    .wb_we_o(wbe[0]), .wb_dst_o(wbd[0]));

  pipe_interlock #(.REG_W(REG_W), .CTRL_W(CTRL_W), .MODE(ILK_LOAD_USE)) u_pipe_interlock_lu (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv[1]),
    .dec_src1_i(s1[1]), .dec_src1_vld_i(s1v[1]), .dec_src2_i(s2[1]), .dec_src2_vld_i(s2v[1]),
    .dec_dst_i(ds[1]), .dec_dst_vld_i(dsv[1]), .dec_is_load_i(ldi[1]), .dec_is_store_i(sti[1]),
    .dec_ctrl_i(ct[1]), .stall_o(stl[1]), .pc_we_o(pwe[1]), .dec_we_o(dwe[1]),
    .ex_valid_o(exv[1]), .ex_bubble_o(exb[1]), .ex_ctrl_o(exc[1]),
    .wb_we_o(wbe[1]), .wb_dst_o(wbd[1]));

  // program under test
  int n_p;
  bit p_v [4], p_s1v [4], p_s2v [4], p_dsv [4], p_ld [4], p_st [4];
  int p_s1 [4], p_s2 [4], p_ds [4], p_ct [4];

  // reference pipeline model
  bit xv, xb, xl, xdv, mv, mdv, wv, wdv;
  int xd, xc, md, wd;

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit hit(bit sv, int s, bit dvv, int d);
    return sv && dvv && (d != 0) && (s == d);
  endfunction

  task automatic drive(int m, bit v, bit a1v, int a1, bit a2v, int a2, bit adv, int ad,
                       bit al, bit ast, int ac);
    dv[m] = v; s1v[m] = a1v; s1[m] = REG_W'(a1); s2v[m] = a2v; s2[m] = REG_W'(a2);
    dsv[m] = adv; ds[m] = REG_W'(ad); ldi[m] = al; sti[m] = ast; ct[m] = CTRL_W'(ac);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) drive(m, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R9", stl[m], 0, "stall_o in reset");
      chk("R9", exv[m], 0, "ex_valid_o in reset");
      chk("R9", exb[m], 0, "ex_bubble_o in reset");
      chk("R9", wbe[m], 0, "wb_we_o in reset");
    end
    {xv, xb, xl, xdv, mv, mdv, wv, wdv} = '0;
    xd = 0; xc = 0; md = 0; wd = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_seq(int m, string stag, string ctag, int exp_stalls);
    int idx = 0;
    int nst = 0;
    do_reset();
    for (int c = 0; c < 8; c++) begin
      bit v = 0, a1v = 0, a2v = 0, adv = 0, al = 0, ast = 0, es;
      int a1 = 0, a2 = 0, ad = 0, ac = 0;
      if (idx < n_p) begin
        v = p_v[idx]; a1v = p_s1v[idx]; a1 = p_s1[idx]; a2v = p_s2v[idx]; a2 = p_s2[idx];
        adv = p_dsv[idx]; ad = p_ds[idx]; al = p_ld[idx]; ast = p_st[idx]; ac = p_ct[idx];
      end
      drive(m, v, a1v, a1, a2v, a2, adv, ad, al, ast, ac);
      #1;
      if (m == 0)
        es = v && (hit(a1v, a1, xv && xdv, xd) || hit(a2v, a2, xv && xdv, xd) ||
                   hit(a1v, a1, mv && mdv, md) || hit(a2v, a2, mv && mdv, md));
      else
        es = v && xv && xl && (hit(a1v, a1, xdv, xd) || (hit(a2v, a2, xdv, xd) && !ast));
      chk(stag, stl[m], es, "stall_o");
      chk("R2", pwe[m], !es, "pc_we_o");
      chk("R2", dwe[m], !es, "dec_we_o");
      chk(xb ? "R3" : "R10", exb[m], xb, "ex_bubble_o");
      chk(xb ? "R3" : "R10", exv[m], xv, "ex_valid_o");
      chk(xb ? "R3" : "R10", exc[m], xc, "ex_ctrl_o");
      chk("R10", wbe[m], wv && wdv && (wd != 0), "wb_we_o");
      if (wv && wdv && (wd != 0)) chk("R10", wbd[m], wd, "wb_dst_o");
      nst += es;
      @(posedge clk);
      wv = mv; wdv = mdv; wd = md;
      mv = xv; mdv = xdv; md = xd;
      if (es) begin
        xv = 0; xb = 1; xl = 0; xdv = 0; xd = 0; xc = 0;
      end else begin
        xv = v; xb = 0; xl = v && al; xdv = v && adv; xd = v ? ad : 0; xc = v ? ac : 0;
        if (idx < n_p) idx++;
      end
      @(negedge clk);
    end
    chk(ctag, nst, exp_stalls, "stall cycle count");
  endtask

  initial begin
    #(180000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) drive(m, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // exhaustive writer/reader pairing sweep
    for (int m = 0; m < 2; m++)
    for (int gap = 0; gap < 2; gap++)
    for (int od = 0; od < 4; od++)
    for (int odv = 0; odv < 2; odv++)
    for (int ol = 0; ol < 2; ol++)
    for (int y1 = 0; y1 < 4; y1++)
    for (int y2 = 0; y2 < 4; y2++)
    for (int y1v = 0; y1v < 2; y1v++)
    for (int y2v = 0; y2v < 2; y2v++)
    for (int yst = 0; yst < 2; yst++) begin
      bit h1, h2;
      int k, ex;
      string st;
      p_v[0] = 1; p_s1v[0] = 0; p_s1[0] = 0; p_s2v[0] = 0; p_s2[0] = 0;
      p_dsv[0] = bit'(odv); p_ds[0] = od; p_ld[0] = bit'(ol); p_st[0] = 0; p_ct[0] = 5;
      p_v[1] = 1; p_s1v[1] = 0; p_s1[1] = 0; p_s2v[1] = 0; p_s2[1] = 0;
      p_dsv[1] = 0; p_ds[1] = 0; p_ld[1] = 0; p_st[1] = 0; p_ct[1] = 6;
      k = 1 + gap;
      p_v[k] = 1; p_s1v[k] = bit'(y1v); p_s1[k] = y1; p_s2v[k] = bit'(y2v); p_s2[k] = y2;
      p_dsv[k] = 1; p_ds[k] = 3; p_ld[k] = 0; p_st[k] = bit'(yst); p_ct[k] = 9;
      n_p = k + 1;
      h1 = hit(bit'(y1v), y1, bit'(odv), od);
      h2 = hit(bit'(y2v), y2, bit'(odv), od);
      if (m == 0) begin
        ex = (h1 || h2) ? (gap == 0 ? 2 : 1) : 0;   // R4
        st = "R1";
      end else begin
        ex = (gap == 0 && ol != 0 && (h1 || (h2 && yst == 0))) ? 1 : 0;  // R7
        st = (h2 && !h1 && yst != 0) ? "R6" : "R5";
      end
      if ((y1 == od && !h1) || (y2 == od && !h2)) st = "R8";
      run_seq(m, st, (m == 0) ? "R4" : "R7", ex);
    end
    // R8: invalid decode slot never stalls, even with matching fields
    for (int m = 0; m < 2; m++)
    for (int d = 1; d < 4; d++) begin
      p_v[0] = 1; p_s1v[0] = 0; p_s1[0] = 0; p_s2v[0] = 0; p_s2[0] = 0;
      p_dsv[0] = 1; p_ds[0] = d; p_ld[0] = 1; p_st[0] = 0; p_ct[0] = 7;
      p_v[1] = 0; p_s1v[1] = 1; p_s1[1] = d; p_s2v[1] = 1; p_s2[1] = d;
      p_dsv[1] = 1; p_ds[1] = d; p_ld[1] = 0; p_st[1] = 0; p_ct[1] = 8;
      n_p = 2;
      run_seq(m, "R8", "R8", 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule